// File: doc/BRIEF.md
# SPI Clock-Stop Serial Port

This block is a word-oriented synchronous serial port that works either as the clock-generating master or as a clocked slave on an SPI-style link. The serial clock rests low, the select line is active low and words travel most significant bit first. Outgoing bits change on falling clock edges and incoming bits are captured on rising clock edges.

In master mode the port divides the system clock by a divide value that is latched when a transfer is accepted. It drops its select output, presents the first data bit at once, and waits one full serial period before the first rising clock edge. After the last falling edge it releases the data line to high impedance. It holds select low for one more low phase, then raises select and pulses `done_o` with the received word.

In slave mode the external clock, select and data lines pass through a two-stage synchronizer that runs on a half-rate enable. Edges are recognised in the system clock domain, so the external clock may be no faster than one period per 16 system clocks.

Top module: `spi_port`

## Requirements
- R1: In master mode one serial clock period lasts 1 + DIV system clocks, where DIV is `div_i` captured at start. A DIV of 0 is treated as 1, which gives a period of 2.
- R2: The low phase lasts floor((DIV+1)/2) system clocks and the high phase takes the rest of the period. The phases are therefore equal for odd DIV, and for even DIV the high phase is one clock longer.
- R3: After reset and whenever idle: `sclk_o` = 0, `sel_n_o` = 1, `sdo_en_o` = 0, `busy_o` = 0, `done_o` = 0.
- R4: The cycle after a master start is accepted, `sel_n_o` is 0, `sdo_en_o` is 1, `busy_o` is 1 and `sdo_o` holds bit WIDTH-1 of `tx_word_i`. The first rising clock edge follows exactly one serial period later.
- R5: Transmit bits leave MSB first. In master mode `sdo_o` changes only together with a falling `sclk_o` edge.
- R6: Receive bits are sampled from `sdi_i` in the system cycle in which `sclk_o` rises, MSB first. The assembled word appears on `rx_word_o` with `done_o`.
- R7: On the WIDTH-th falling edge `sdo_en_o` goes to 0. `sel_n_o` rises one low phase later, and in that same cycle `done_o` = 1 and `busy_o` = 0.
- R8: `done_o` is a single-cycle pulse. `busy_o` stays high from the cycle after acceptance until the done cycle.
- R9: A start request while busy is ignored. `div_i` and `tx_word_i` are captured only when a transfer is accepted.
- R10: In slave mode, a synchronized falling edge on `sel_n_i` opens a frame. The port then drives the MSB of `tx_word_i` with `sdo_en_o` = 1 and samples `sdi_i` on each external rising edge, while `sclk_o` stays 0 and `sel_n_o` stays 1. The external clock period is at least 16 system clocks.
- R11: In slave mode, the synchronized WIDTH-th falling edge sets `sdo_en_o` to 0, pulses `done_o` with the received word and clears `busy_o`. `start_i` has no effect in slave mode.
- R12: If `sel_n_i` rises before WIDTH bits have been exchanged, the frame is dropped: `sdo_en_o` = 0, `busy_o` = 0, and no `done_o`.
- R13: `slave_mode_i` is looked at only while idle. Changing it during a transfer does not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_mode_i | input | 1 | 1 = slave, 0 = master; sampled while idle |
| div_i | input | DIV_W | Master clock divide value |
| start_i | input | 1 | Master transfer request |
| tx_word_i | input | WIDTH | Word to send |
| sdi_i | input | 1 | Serial data in |
| sclk_i | input | 1 | External serial clock (slave) |
| sel_n_i | input | 1 | External active-low select (slave) |
| sclk_o | output | 1 | Serial clock out (master) |
| sel_n_o | output | 1 | Active-low select out (master) |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Data output enable; 0 means high impedance |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rx_word_o | output | WIDTH | Received word, updated with done |

## Verification
Two functions can land in the same cycle. The first is a start request meeting a running transfer at the very cycle a clock phase ends. The second is a change to `div_i` and `slave_mode_i` made alongside that request. The bench raises `start_i` with a different word and divide value, and flips the mode, one phase into a master transfer. It then judges from the outputs alone: every measured phase length, the transmitted bit stream and the received word must still match the values expected from the original request. In slave mode, a frame dropped early is checked for the absence of `done_o` and for a released data line.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_SLAVE
  } port_state_e;

  // bit positions inside the synchronized edge bundle
  localparam int SY_CLK = 0;
  localparam int SY_SEL = 1;
endpackage

// File: rtl/spi_port_timer.sv
module spi_port_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len - CW'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign expire = (cnt == '0);

  // R1
  len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> (len != '0));
endmodule

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int         N       = 2,
  parameter logic [N:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] edg_i,
  input  logic         dat_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] chg_o,
  output logic         dat_o
);
  localparam int TOT = N + 1;

  logic           ce;
  logic [TOT-1:0] s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce    <= 1'b0;
      s1    <= RST_VAL;
      s2    <= RST_VAL;
      s3    <= RST_VAL;
      chg_o <= '0;
    end else begin
      ce <= ~ce;
      if (ce) begin
        s1    <= {dat_i, edg_i};
        s2    <= s1;
        s3    <= s2;
        chg_o <= s2[N-1:0] ^ s3[N-1:0];
      end else begin
        chg_o <= '0;
      end
    end
  end

  assign lvl_o = s3[N-1:0];
  assign dat_o = s3[N];

  // R10
  chg_single_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_o != '0) |=> (chg_o == '0));
endmodule

// File: rtl/spi_port_shreg.sv
module spi_port_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sample,
  input  logic         din,
  output logic         tx_msb,
  output logic [W-1:0] rx_q
);
  logic [W-1:0] tx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
      rx_q  <= '0;
    end else begin
      if (load) begin
        tx_sr <= load_val;
        rx_q  <= '0;
      end else begin
        if (shift)  tx_sr <= {tx_sr[W-2:0], 1'b0};
        if (sample) rx_q  <= {rx_q[W-2:0], din};
      end
    end
  end

  assign tx_msb = tx_sr[W-1];

  // R5
  no_load_shift_chk: assert property (@(posedge clk) disable iff (rst)
    !(load && (shift || sample)));
endmodule

// File: rtl/spi_port.sv
module spi_port #(
  parameter int WIDTH = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slave_mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             start_i,
  input  logic [WIDTH-1:0] tx_word_i,
  input  logic             sdi_i,
  input  logic             sclk_i,
  input  logic             sel_n_i,
  output logic             sclk_o,
  output logic             sel_n_o,
  output logic             sdo_o,
  output logic             sdo_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] rx_word_o
);
  import spi_port_pkg::*;

  localparam int CW = DIV_W + 1;
  localparam int BW = $clog2(WIDTH + 1);

  port_state_e      state;
  logic [DIV_W-1:0] div_q, eff;
  logic [CW-1:0]    per_q, low_q, high_q, per_new, tmr_len;
  logic [BW-1:0]    bits;
  logic             mode_q, last, expire, tmr_load;
  logic             sh_load, sh_shift, sh_sample, sh_din, tx_msb;
  logic [WIDTH-1:0] rx_q;
  logic [1:0]       sy_lvl, sy_chg;
  logic             sy_dat;
  logic             sl_assert, sl_release, sl_rise, sl_fall;

  // divide value and phase lengths
  assign eff     = (div_i == '0) ? DIV_W'(1) : div_i;
  assign per_new = {1'b0, eff} + CW'(1);
  assign per_q   = {1'b0, div_q} + CW'(1);
  assign low_q   = per_q >> 1;
  assign high_q  = per_q - low_q;
  assign last    = (bits == BW'(WIDTH));

  // slave line synchronizer
  spi_port_sync #(
    .N       (2),
    .RST_VAL (3'b010)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .edg_i ({sel_n_i, sclk_i}),
    .dat_i (sdi_i),
    .lvl_o (sy_lvl),
    .chg_o (sy_chg),
    .dat_o (sy_dat)
  );

  assign sl_assert  = sy_chg[SY_SEL] & ~sy_lvl[SY_SEL];
  assign sl_release = sy_chg[SY_SEL] &  sy_lvl[SY_SEL];
  assign sl_rise    = sy_chg[SY_CLK] &  sy_lvl[SY_CLK];
  assign sl_fall    = sy_chg[SY_CLK] & ~sy_lvl[SY_CLK];

  spi_port_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .len    (tmr_len),
    .expire (expire)
  );

  spi_port_shreg #(.W(WIDTH)) u_shreg (
    .clk      (clk),
    .rst      (rst),
    .load     (sh_load),
    .load_val (tx_word_i),
    .shift    (sh_shift),
    .sample   (sh_sample),
    .din      (sh_din),
    .tx_msb   (tx_msb),
    .rx_q     (rx_q)
  );

  assign sdo_o  = tx_msb;
  assign sh_din = (state == ST_SLAVE) ? sy_dat : sdi_i;

  // control decode
  always_comb begin
    tmr_load  = 1'b0;
    tmr_len   = per_q;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    sh_sample = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (slave_mode_i) begin
          sh_load = sl_assert;
        end else if (start_i) begin
          sh_load  = 1'b1;
          tmr_load = 1'b1;
          tmr_len  = per_new;
        end
      end
      ST_LEAD, ST_LOW: begin
        if (expire) begin
          tmr_load  = 1'b1;
          tmr_len   = high_q;
          sh_sample = 1'b1;
        end
      end
      ST_HIGH: begin
        if (expire) begin
          tmr_load = 1'b1;
          tmr_len  = low_q;
          sh_shift = !last;
        end
      end
      ST_SLAVE: begin
        if (!sl_release) begin
          sh_sample = sl_rise;
          sh_shift  = sl_fall && !last && (bits != '0);
        end
      end
      default: ;
    endcase
  end

  // sequencer with registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      div_q     <= DIV_W'(1);
      mode_q    <= 1'b0;
      bits      <= '0;
      sclk_o    <= 1'b0;
      sel_n_o   <= 1'b1;
      sdo_en_o  <= 1'b0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      rx_word_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (slave_mode_i) begin
            if (sl_assert) begin
              mode_q   <= 1'b1;
              bits     <= '0;
              sdo_en_o <= 1'b1;
              busy_o   <= 1'b1;
              state    <= ST_SLAVE;
            end
          end else if (start_i) begin
            mode_q   <= 1'b0;
            div_q    <= eff;
            bits     <= '0;
            sel_n_o  <= 1'b0;
            sdo_en_o <= 1'b1;
            busy_o   <= 1'b1;
            state    <= ST_LEAD;
          end
        end
        ST_LEAD, ST_LOW: begin
          if (expire) begin
            sclk_o <= 1'b1;
            bits   <= bits + BW'(1);
            state  <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (expire) begin
            sclk_o <= 1'b0;
            if (last) begin
              sdo_en_o <= 1'b0;
              state    <= ST_TAIL;
            end else begin
              state <= ST_LOW;
            end
          end
        end
        ST_TAIL: begin
          if (expire) begin
            sel_n_o   <= 1'b1;
            busy_o    <= 1'b0;
            done_o    <= 1'b1;
            rx_word_o <= rx_q;
            state     <= ST_IDLE;
          end
        end
        ST_SLAVE: begin
          if (sl_release) begin
            sdo_en_o <= 1'b0;
            busy_o   <= 1'b0;
            state    <= ST_IDLE;
          end else if (sl_rise) begin
            bits <= bits + BW'(1);
          end else if (sl_fall && last) begin
            sdo_en_o  <= 1'b0;
            busy_o    <= 1'b0;
            done_o    <= 1'b1;
            rx_word_o <= rx_q;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!sclk_o && sel_n_o));

  // R7
  deselect_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && sel_n_o) |-> !sdo_en_o);

  // R9
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(div_q));

  // R5
  shift_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && busy_o && $past(busy_o) && !$fell(sclk_o)) |-> $stable(sdo_o));
endmodule

// File: tb/spi_port_bench.sv
`timescale 1ns/1ps
module spi_port_bench;
  localparam int W  = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          slave_mode = 1'b0;
  logic [DW-1:0] div = '0;
  logic          start = 1'b0;
  logic [W-1:0]  tx_word = '0;
  logic          sdi = 1'b0;
  logic          sclk_i = 1'b0;
  logic          sel_n_i = 1'b1;
  logic          sclk_o, sel_n_o, sdo_o, sdo_en_o, busy_o, done_o;
  logic [W-1:0]  rx_word_o;

  int n_chk = 0;
  int n_bad = 0;
  int done_cnt = 0;
  logic [W-1:0] done_rx = '0;

  always #2 clk = ~clk;

  spi_port #(.WIDTH(W), .DIV_W(DW)) u_spi_port (
    .clk(clk), .rst(rst), .slave_mode_i(slave_mode), .div_i(div),
    .start_i(start), .tx_word_i(tx_word), .sdi_i(sdi), .sclk_i(sclk_i),
    .sel_n_i(sel_n_i), .sclk_o(sclk_o), .sel_n_o(sel_n_o), .sdo_o(sdo_o),
    .sdo_en_o(sdo_en_o), .busy_o(busy_o), .done_o(done_o),
    .rx_word_o(rx_word_o)
  );

  always @(negedge clk) if (!rst && done_o) begin
    done_cnt++;
    done_rx = rx_word_o;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_div(input int d);
    return (d == 0) ? 1 : d;
  endfunction
  function automatic int per_len(input int d);
    return eff_div(d) + 1;
  endfunction
  function automatic int low_len(input int d);
    return (eff_div(d) + 1) / 2;
  endfunction
  function automatic int high_len(input int d);
    return per_len(d) - low_len(d);
  endfunction

  task automatic run_master(input logic [W-1:0] tx, input logic [W-1:0] rxp,
                            input int d, input bit disturb);
    int P, L, H, run, rises, falls;
    logic ps;
    logic [W-1:0] seen;
    bit fin;
    P = per_len(d); L = low_len(d); H = high_len(d);
    @(negedge clk);
    slave_mode = 1'b0; div = DW'(d); tx_word = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0; sdi = rxp[W-1];
    // R4 select, enable and MSB right after acceptance
    chk(!sel_n_o && sdo_en_o && busy_o && !sclk_o, "R4", {sel_n_o, sdo_en_o, busy_o, sclk_o}, 4'b0110);
    chk(sdo_o == tx[W-1], "R4", sdo_o, tx[W-1]);
    run = 1; rises = 0; falls = 0; ps = 1'b0; seen = '0; fin = 1'b0;
    for (int c = 0; c < (W + 3) * P + 20 && !fin; c++) begin
      @(negedge clk);
      if (disturb && c == P) begin
        start = 1'b1; tx_word = ~tx; div = DW'(d + 2); slave_mode = 1'b1;
      end else if (disturb) begin
        start = 1'b0;
      end
      if (sclk_o !== ps) begin
        if (sclk_o) begin
          // R4 lead time on the first edge, R2 low phase afterwards
          chk(run == ((rises == 0) ? P : L), (rises == 0) ? "R4" : "R2", run, (rises == 0) ? P : L);
          seen = {seen[W-2:0], sdo_o};
          rises++;
        end else begin
          chk(run == H, "R2", run, H);
          falls++;
          if (falls < W) sdi = rxp[W-1-falls];
          // R7 line released only after the last falling edge
          chk(sdo_en_o == (falls < W), "R7", sdo_en_o, falls < W);
        end
        run = 1; ps = sclk_o;
      end else if (sel_n_o) begin
        chk(run == L, "R7", run, L);
        chk(done_o && !busy_o, "R8", {done_o, busy_o}, 2'b10);
        chk(rx_word_o == rxp, "R6", rx_word_o, rxp);
        chk(seen == tx, disturb ? "R9" : "R5", seen, tx);
        chk(rises == W, "R1", rises, W);
        fin = 1'b1;
      end else begin
        run++;
      end
    end
    chk(fin, disturb ? "R13" : "R1", fin, 1);
    start = 1'b0; slave_mode = 1'b0;
    @(negedge clk);
    chk(!done_o && !busy_o && sel_n_o, "R8", {done_o, busy_o, sel_n_o}, 3'b001);
  endtask

  task automatic run_slave(input logic [W-1:0] tx, input logic [W-1:0] rxp, input int nbits);
    logic [W-1:0] got;
    int d0;
    @(negedge clk);
    slave_mode = 1'b1; tx_word = tx;
    repeat (4) @(negedge clk);
    start = 1'b1; sel_n_i = 1'b0; sdi = rxp[W-1];
    @(negedge clk);
    start = 1'b0;
    repeat (15) @(negedge clk);
    // R10 frame opened, MSB driven; R11 start did not launch a master run
    chk(sdo_en_o && busy_o && sdo_o == tx[W-1], "R10", {sdo_en_o, busy_o, sdo_o}, {2'b11, tx[W-1]});
    chk(!sclk_o && sel_n_o, "R11", {sclk_o, sel_n_o}, 2'b01);
    got = '0; d0 = done_cnt;
    for (int i = 0; i < nbits; i++) begin
      got[W-1-i] = sdo_o;
      sclk_i = 1'b1;
      repeat (10) @(negedge clk);
      sclk_i = 1'b0;
      if (i + 1 < W) sdi = rxp[W-2-i];
      repeat (10) @(negedge clk);
    end
    if (nbits == W) begin
      chk(done_cnt == d0 + 1, "R11", done_cnt - d0, 1);
      chk(done_rx == rxp, "R11", done_rx, rxp);
      chk(got == tx, "R10", got, tx);
      chk(!sdo_en_o && !busy_o, "R11", {sdo_en_o, busy_o}, 2'b00);
      sel_n_i = 1'b1;
      repeat (10) @(negedge clk);
    end else begin
      chk(busy_o && sdo_en_o, "R12", {busy_o, sdo_en_o}, 2'b11);
      sel_n_i = 1'b1;
      repeat (10) @(negedge clk);
      chk(!busy_o && !sdo_en_o, "R12", {busy_o, sdo_en_o}, 2'b00);
      chk(done_cnt == d0, "R12", done_cnt - d0, 0);
      chk(got[W-1 -: 3] == tx[W-1 -: 3], "R12", got[W-1 -: 3], tx[W-1 -: 3]);
    end
    slave_mode = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state
    chk(!sclk_o && sel_n_o && !sdo_en_o && !busy_o && !done_o, "R3",
        {sclk_o, sel_n_o, sdo_en_o, busy_o, done_o}, 5'b01000);
    // directed divide values: zero, odd, even, larger even and odd
    run_master(16'hA5C3, 16'h3C5A, 0, 1'b0);
    run_master(16'h8001, 16'hFFFF, 1, 1'b0);
    run_master(16'h7FFE, 16'h0000, 2, 1'b0);
    run_master(16'h1234, 16'hBEEF, 6, 1'b0);
    run_master(16'hF00D, 16'h0F0F, 5, 1'b0);
    // R9 R13 start, divide and mode changes during a transfer
    run_master(16'hC0DE, 16'h5A5A, 3, 1'b1);
    run_master(16'h0001, 16'h8000, 4, 1'b1);
    for (int k = 0; k < 8; k++) begin
      run_master(W'($urandom), W'($urandom), int'($urandom_range(0, 9)), 1'b0);
    end
    run_slave(16'h9C6B, 16'hD00F, W);
    run_slave(W'($urandom), W'($urandom), W);
    run_slave(16'hE001, 16'h1234, 3);
    run_slave(16'h0FF0, 16'hA001, W);
    run_master(16'h5AA5, 16'hC33C, 2, 1'b0);
    @(negedge clk);
    chk(!busy_o && !sdo_en_o && sel_n_o, "R3", {busy_o, sdo_en_o, sel_n_o}, 3'b001);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule